// File: doc/BRIEF.md
# System Control Register with Reset-Aware Boot Mode

This block is a 16-bit system control word that sits on a simple register port. Most of its bits are single-bit control flags that software reads and writes. Three of its bits hold the boot mode. The register loads the boot mode from three external mode pins only when a hard reset ends. A hard reset comes from the external reset pin or from power-on. When several hard resets overlap, the capture waits until the last one releases.

Watchdog and software resets clear the control flags but leave the boot mode alone. Software can therefore write a new mode, request a software reset through the register, and restart into that mode without any change to the pins.

The read path is registered. A four-bit revision field, set by a parameter, is read-only. Two reserved bits always read zero.

Top module: `sys_ctl_reg`

## Requirements
- R1: Bits 15 and 7 of `rdata` always read 0, and writing 1 to them has no effect.
- R2: Bits 11:8 of `rdata` always read the parameter `REV_ID` (default 1), and writes to them are ignored.
- R3: While the pin reset or the power-on reset is high, `rdata` settles to 0x0100 (boot mode 0, revision 1, all flags clear).
- R4: Bits 14:12 (boot mode) load the value of `mode_pins` on the first rising edge at which both `rst_pin` and `rst_por` are low after either was high. If one hard reset releases while the other is still high, no capture happens. After the capture, later changes on the pins have no effect.
- R5: A watchdog reset (`rst_wdog`) leaves the boot-mode field unchanged.
- R6: A software reset (`rst_soft`) leaves the boot-mode field unchanged, so a value written before it survives.
- R7: Outside reset, a write with `wr_en` high stores `wdata[14:12]` as the boot mode.
- R8: The flag bits are plain read/write storage: bit 0 is the wait disable, bit 1 the stop disable, bit 3 the data-memory disable, bit 4 the program-memory disable, bit 5 the clock-output disable, and bit 6 the debug enable.
- R9: Any reset source clears all flag bits, and writes presented while any reset is high are ignored.
- R10: Writing 1 to bit 2 raises `swrst_req` for exactly the one cycle after the write edge, and bit 2 always reads 0.
- R11: `rdata` shows a write from the second rising edge after the cycle in which `wr_en` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin | input | 1 | External reset pin, synchronous, active high |
| rst_por | input | 1 | Power-on reset, synchronous, active high |
| rst_wdog | input | 1 | Watchdog reset, synchronous, active high |
| rst_soft | input | 1 | Software reset from the sequencer, active high |
| mode_pins | input | 3 | External boot-mode pins |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| swrst_req | output | 1 | One-cycle software-reset request |

## Verification
The hardest case to reach from the ports is two hard resets that overlap. The pin reset releases while the power-on reset is still high, and the mode pins change during that gap. The bench builds this case directly. It then releases the power-on reset with a second pin value, checks that only this value is captured, and changes the pins once more to confirm the field no longer follows them. A software write followed by watchdog and software resets then shows that the written mode survives both resets.

// File: rtl/sys_ctl_pkg.sv
package sys_ctl_pkg;
  localparam int REG_W     = 16;
  localparam int BOOT_W    = 3;
  localparam int BOOT_LSB  = 12;
  localparam int REV_W     = 4;
  localparam int REV_LSB   = 8;
  localparam int SWRST_BIT = 2;
  localparam int NUM_FLAGS = 6;

  // bit position of control flag i inside the register word
  function automatic int flag_pos(input int idx);
    case (idx)
      0:       flag_pos = 0;  // wait disable
      1:       flag_pos = 1;  // stop disable
      2:       flag_pos = 3;  // data memory disable
      3:       flag_pos = 4;  // program memory disable
      4:       flag_pos = 5;  // clock output disable
      default: flag_pos = 6;  // debug enable
    endcase
  endfunction
endpackage

// File: rtl/sys_ctl_rst_arb.sv
module sys_ctl_rst_arb (
  input  logic clk,
  input  logic rst_pin,
  input  logic rst_por,
  input  logic rst_wdog,
  input  logic rst_soft,
  output logic hard_rst,
  output logic soft_rst,
  output logic any_rst,
  output logic hard_fall
);
  logic hard_q;

  assign hard_rst = rst_pin | rst_por;
  assign soft_rst = rst_wdog | rst_soft;
  assign any_rst  = hard_rst | soft_rst;

  always_ff @(posedge clk) begin
    hard_q <= hard_rst;
  end

  assign hard_fall = hard_q & ~hard_rst;

  AST_FALL_ONCE: assert property (@(posedge clk) disable iff (hard_rst)
    hard_fall |=> !hard_fall); // R4
endmodule

// File: rtl/sys_ctl_boot.sv
module sys_ctl_boot
  import sys_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              hard_rst,
  input  logic              hard_fall,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [BOOT_W-1:0] wr_boot,
  input  logic [BOOT_W-1:0] mode_pins,
  output logic [BOOT_W-1:0] boot_q
);
  always_ff @(posedge clk) begin
    if (hard_rst)       boot_q <= '0;
    else if (hard_fall) boot_q <= mode_pins;
    else if (soft_rst)  boot_q <= boot_q;
    else if (wr_en)     boot_q <= wr_boot;
  end

  AST_BOOT_CAPTURE: assert property (@(posedge clk) disable iff (hard_rst)
    hard_fall |=> boot_q == $past(mode_pins)); // R4
  AST_BOOT_SOFT_HOLD: assert property (@(posedge clk) disable iff (hard_rst)
    (soft_rst && !hard_fall) |=> $stable(boot_q)); // R5
endmodule

// File: rtl/sys_ctl_flags.sv
module sys_ctl_flags
  import sys_ctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 hard_rst,
  input  logic                 any_rst,
  input  logic                 wr_en,
  input  logic [NUM_FLAGS-1:0] wr_flags,
  input  logic                 wr_swrst,
  output logic [NUM_FLAGS-1:0] flags_q,
  output logic                 swrst_q
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (any_rst)    flags_q[i] <= 1'b0;
      else if (wr_en) flags_q[i] <= wr_flags[i];
    end
  end

  always_ff @(posedge clk) begin
    if (any_rst) swrst_q <= 1'b0;
    else         swrst_q <= wr_en & wr_swrst;
  end

  AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (hard_rst)
    any_rst |=> flags_q == '0); // R9
  AST_SWRST_SINGLE: assert property (@(posedge clk) disable iff (hard_rst)
    swrst_q |=> !swrst_q); // R10
endmodule

// File: rtl/sys_ctl_reg.sv
module sys_ctl_reg
  import sys_ctl_pkg::*;
#(
  parameter logic [3:0] REV_ID = 4'h1
) (
  input  logic        clk,
  input  logic        rst_pin,
  input  logic        rst_por,
  input  logic        rst_wdog,
  input  logic        rst_soft,
  input  logic [2:0]  mode_pins,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        swrst_req
);
  logic                 hard_rst, soft_rst, any_rst, hard_fall;
  logic [BOOT_W-1:0]    boot_q;
  logic [NUM_FLAGS-1:0] flags_q;
  logic [NUM_FLAGS-1:0] wr_flags;
  logic [REG_W-1:0]     rd_next;
  logic [REG_W-1:0]     rdata_q;
  logic                 wr_ok;
  logic                 unused_wbits;

  assign wr_ok        = wr_en & ~any_rst;
  assign unused_wbits = ^{wdata[15], wdata[11:7]};

  sys_ctl_rst_arb u_arb (
    .clk(clk), .rst_pin(rst_pin), .rst_por(rst_por), .rst_wdog(rst_wdog),
    .rst_soft(rst_soft), .hard_rst(hard_rst), .soft_rst(soft_rst),
    .any_rst(any_rst), .hard_fall(hard_fall)
  );

  sys_ctl_boot u_boot (
    .clk(clk), .hard_rst(hard_rst), .hard_fall(hard_fall), .soft_rst(soft_rst),
    .wr_en(wr_ok), .wr_boot(wdata[BOOT_LSB +: BOOT_W]), .mode_pins(mode_pins),
    .boot_q(boot_q)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_wsel
    assign wr_flags[i] = wdata[flag_pos(i)];
  end

  sys_ctl_flags u_flags (
    .clk(clk), .hard_rst(hard_rst), .any_rst(any_rst), .wr_en(wr_ok),
    .wr_flags(wr_flags), .wr_swrst(wdata[SWRST_BIT]), .flags_q(flags_q),
    .swrst_q(swrst_req)
  );

  always_comb begin
    rd_next = '0;
    rd_next[BOOT_LSB +: BOOT_W] = boot_q;
    rd_next[REV_LSB +: REV_W]   = REV_ID;
    for (int i = 0; i < NUM_FLAGS; i++) rd_next[flag_pos(i)] = flags_q[i];
  end

  always_ff @(posedge clk) begin
    if (hard_rst) begin
      rdata_q <= '0;
      rdata_q[REV_LSB +: REV_W] <= REV_ID;
    end else begin
      rdata_q <= rd_next;
    end
  end

  assign rdata = rdata_q;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (hard_rst)
    (rdata[15] == 1'b0) && (rdata[7] == 1'b0)); // R1
  AST_SWRST_READS_ZERO: assert property (@(posedge clk) disable iff (hard_rst)
    swrst_req |=> rdata[SWRST_BIT] == 1'b0); // R10
  AST_REV_FIXED: assert property (@(posedge clk) disable iff (hard_rst)
    $past(hard_rst) == 1'b0 |-> rdata[REV_LSB +: REV_W] == REV_ID); // R2
endmodule

// File: tb/sys_ctl_reg_test.sv
`timescale 1ns/1ps
module sys_ctl_reg_test;
  logic        clk = 1'b0;
  logic        rst_pin = 1'b0, rst_por = 1'b1, rst_wdog = 1'b0, rst_soft = 1'b0;
  logic [2:0]  mode_pins = 3'd0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        swrst_req;
  int          n_chk = 0, n_fail = 0;

  localparam logic [15:0] RW_MASK = 16'h707B;
  localparam logic [15:0] REV_BITS = 16'h0100;
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{16'hFFFF, 16'h0000, 16'h5055, 16'h202A,
                                       16'h8F80, 16'h7004, 16'h1041, 16'h6022};

  always #2 clk = ~clk;

  sys_ctl_reg uut (
    .clk(clk), .rst_pin(rst_pin), .rst_por(rst_por), .rst_wdog(rst_wdog),
    .rst_soft(rst_soft), .mode_pins(mode_pins), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .swrst_req(swrst_req)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [15:0] w);
    @(negedge clk); wr_en = 1'b1; wdata = w;
    @(negedge clk); wr_en = 1'b0; wdata = 16'h0;
  endtask

  initial begin
    #80000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    mode_pins = 3'd6;
    cyc(3);
    check("R3 power-on reset value", rdata, 16'h0100);
    rst_por = 1'b0;
    cyc(2);
    check("R4 capture at power-on release", rdata, 16'h6100);

    // vector walk: write, check pulse, check readback
    for (int v = 0; v < NV; v++) begin
      do_write(VEC[v]);
      check("R10 swrst pulse", {15'd0, swrst_req}, {15'd0, VEC[v][2]});
      @(negedge clk);
      check("R1 R2 R7 R8 R11 readback", rdata, (VEC[v] & RW_MASK) | REV_BITS);
      check("R10 pulse single cycle", {15'd0, swrst_req}, 16'd0);
    end

    // R11: not yet visible one edge after write
    do_write(16'h0041);
    check("R11 latency", rdata, 16'h6122);
    @(negedge clk);
    check("R11 visible", rdata, 16'h0141);

    // overlapping hard resets: R4
    @(negedge clk); rst_pin = 1'b1; rst_por = 1'b1; mode_pins = 3'd2;
    cyc(2);
    check("R3 pin reset value", rdata, 16'h0100);
    rst_pin = 1'b0;
    cyc(3);
    check("R4 no capture while POR held", rdata, 16'h0100);
    rst_por = 1'b0; mode_pins = 3'd5;
    cyc(1);
    mode_pins = 3'd7;
    cyc(2);
    check("R4 capture at last release", rdata, 16'h5100);
    cyc(2);
    check("R4 pins ignored after capture", rdata, 16'h5100);

    // watchdog keeps written boot mode, clears flags: R5 R9
    do_write(16'h607B);
    @(negedge clk);
    check("R8 flags set", rdata, 16'h617B);
    rst_wdog = 1'b1; mode_pins = 3'd1;
    cyc(2);
    check("R5 boot kept in watchdog reset", rdata, 16'h6100);
    wr_en = 1'b1; wdata = 16'h7FFF;
    cyc(1);
    wr_en = 1'b0; wdata = 16'h0;
    rst_wdog = 1'b0;
    cyc(2);
    check("R9 write during reset ignored", rdata, 16'h6100);

    // software reboot into a new mode: R6 R10
    do_write(16'h3004);
    check("R10 request from reboot write", {15'd0, swrst_req}, 16'd1);
    rst_soft = 1'b1;
    check("R10 bit reads zero", rdata, 16'h6100);
    cyc(2);
    rst_soft = 1'b0;
    cyc(2);
    check("R6 boot kept over software reset", rdata, 16'h3100);
    check("R10 no pulse after reset", {15'd0, swrst_req}, 16'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule